// File: doc/BRIEF.md
# Token-Pass Readout Trigger Manager

This block sits between the level-1 trigger distribution and a daisy chain of pixel readout chips. Every trigger and clear it receives is forwarded to the chips one cycle later. Each trigger is also counted. The current count, taken as an 8-bit event number, is queued in a 16-entry first-in first-out stack, where it waits its turn for readout.

Whenever the sequencer is idle and an event is waiting, it takes the oldest entry and shifts out a header word that carries the event number. It then sends a single-cycle token into the chip chain and waits for the token to come back. Finally it shifts out a trailer word of status bits. A trigger that arrives while more than eight events are already waiting is still queued and counted. Its event is marked as suppressed, so no token is sent for it, and its trailer follows its header at once. Clear empties the queue and restarts the event count.

Top module: `token_readout_mgr`

## Requirements
- R1: `trigOut` and `clrOut` repeat `trigIn` and `clrIn` with exactly one cycle of delay.
- R2: A trigger without a coincident clear adds one entry to the queue. `stackLevel` gives the number of waiting events and never exceeds DEPTH.
- R3: A trigger that meets a full queue in a cycle with no pop is discarded and sets `ovfFlag`. `ovfFlag` then stays high until a clear or a reset.
- R4: A trigger in the same cycle as a pop leaves `stackLevel` unchanged. A trigger is accepted into a full queue when a pop happens in that cycle.
- R5: The event number stored with a trigger equals the number of triggers seen since reset or the last clear, modulo 2^EVT_W. The first trigger gets 0.
- R6: A clear empties the queue, zeroes the trigger count and drops `ovfFlag` at the same clock edge. Clear takes priority over a trigger or a pop in the same cycle.
- R7: `inhibit` is high whenever `stackLevel` exceeds LIMIT (8). A trigger that arrives while `inhibit` is high is queued with a suppress mark.
- R8: When the sequencer is idle, the queue is not empty and no clear is present, the oldest entry is popped. From the next cycle `frameValid` is high for EVT_W+2 cycles. During those cycles `serBit` carries the header word {2'b10, event number}, most significant bit first.
- R9: For an unmarked event, `tokenOut` is high for exactly one cycle right after the header. The sequencer then waits for `tokenRet`. `tokenRet` has no effect at any other time.
- R10: For a suppress-marked event, `tokenOut` stays low and the trailer starts in the cycle after the last header bit.
- R11: The trailer word is {2'b01, suppress mark, `ovfFlag` as it stands when the trailer is loaded, EVT_W-2 zero bits}, sent most significant bit first. It is followed by at least one idle cycle with `busy` low. `busy` is high from the header through the trailer.
- R12: `serBit` is 0 whenever `frameValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Level-1 trigger, one cycle per trigger |
| clrIn | input | 1 | Clear: empties the queue and restarts the count |
| tokenRet | input | 1 | Token returning from the end of the chip chain |
| trigOut | output | 1 | Trigger forwarded to the chips |
| clrOut | output | 1 | Clear forwarded to the chips |
| tokenOut | output | 1 | Readout token launched into the chip chain |
| serBit | output | 1 | Serial header/trailer bit |
| frameValid | output | 1 | `serBit` carries a header or trailer bit |
| busy | output | 1 | Sequencer is handling an event |
| stackLevel | output | LVL_W (5) | Number of queued events |
| inhibit | output | 1 | Backlog is above the suppression limit |
| ovfFlag | output | 1 | Sticky flag: a trigger was lost to a full queue |

## Verification
The bench builds the block with its default parameters: DEPTH 16, EVT_W 8 and LIMIT 8. Dense trigger bursts therefore push the backlog past the limit and fill the queue within a few dozen cycles, which brings suppressed events, dropped triggers and a pop coinciding with a push into a full queue within reach. A long run without clears sends more than 256 triggers, so the 8-bit event number wraps inside the run. Random `tokenRet` pulses outside the wait state exercise the rule that a stray return does nothing.

// File: rtl/trm_pkg.sv
package trm_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HDR   = 3'd1,
    S_TOKEN = 3'd2,
    S_WAIT  = 3'd3,
    S_TRL   = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic loadHeader;
    logic loadTrailer;
    logic shiftEn;
  } seq_ctrl_t;

  localparam logic [1:0] HDR_TAG = 2'b10;
  localparam logic [1:0] TRL_TAG = 2'b01;

endpackage

// File: rtl/trm_stack.sv
module trm_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= advance(wrPtr);
      if (pop)  rdPtr <= advance(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/trm_datapath.sv
module trm_datapath
  import trm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int EVT_W  = 8,
  parameter int LIMIT  = 8,
  parameter int LVL_W  = 5,
  parameter int WORD_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             clrIn,
  input  seq_ctrl_t        ctrl,
  input  logic             frameValid,
  output logic             trigOut,
  output logic             clrOut,
  output logic             serBit,
  output logic [LVL_W-1:0] stackLevel,
  output logic             inhibit,
  output logic             ovfFlag,
  output logic             stackEmpty,
  output logic             suppLatched
);
  localparam int ENTRY_W = EVT_W + 1;
  localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LIMIT_L = LVL_W'(LIMIT);

  logic [EVT_W-1:0]   evtCnt;
  logic [ENTRY_W-1:0] headEntry, newEntry;
  logic [WORD_W-1:0]  shReg;
  logic               stackFull, doPush, doPop;

  assign stackFull  = (stackLevel == FULL_L);
  assign stackEmpty = (stackLevel == '0);
  assign inhibit    = (stackLevel > LIMIT_L);
  assign doPop      = ctrl.loadHeader;
  assign doPush     = trigIn & ~clrIn & (~stackFull | doPop);
  assign newEntry   = {inhibit, evtCnt};

  trm_stack #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .LVL_W(LVL_W)) u_stack (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (clrIn),
    .push   (doPush),
    .pop    (doPop),
    .wrData (newEntry),
    .rdData (headEntry),
    .level  (stackLevel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigOut <= 1'b0;
      clrOut  <= 1'b0;
    end else begin
      trigOut <= trigIn;
      clrOut  <= clrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrIn) begin
      evtCnt  <= '0;
      ovfFlag <= 1'b0;
    end else if (trigIn) begin
      evtCnt <= evtCnt + 1'b1;
      if (stackFull && !doPop) ovfFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg       <= '0;
      suppLatched <= 1'b0;
    end else if (ctrl.loadHeader) begin
      shReg       <= {HDR_TAG, headEntry[EVT_W-1:0]};
      suppLatched <= headEntry[EVT_W];
    end else if (ctrl.loadTrailer) begin
      shReg <= {TRL_TAG, suppLatched, ovfFlag, {(EVT_W-2){1'b0}}};
    end else if (ctrl.shiftEn) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serBit = frameValid & shReg[WORD_W-1];

endmodule

// File: rtl/trm_control.sv
module trm_control
  import trm_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrIn,
  input  logic      tokenRet,
  input  logic      stackEmpty,
  input  logic      suppLatched,
  output seq_ctrl_t ctrl,
  output logic      tokenOut,
  output logic      frameValid,
  output logic      busy
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  seq_state_t       state, stateNext;
  logic [CNT_W-1:0] bitCnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = bitCnt;
    ctrl      = '0;
    case (state)
      S_IDLE: begin
        if (!stackEmpty && !clrIn) begin
          ctrl.loadHeader = 1'b1;
          stateNext       = S_HDR;
          cntNext         = '0;
        end
      end
      S_HDR: begin
        if (bitCnt == LAST_BIT) begin
          cntNext = '0;
          if (suppLatched) begin
            ctrl.loadTrailer = 1'b1;
            stateNext        = S_TRL;
          end else begin
            ctrl.shiftEn = 1'b1;
            stateNext    = S_TOKEN;
          end
        end else begin
          ctrl.shiftEn = 1'b1;
          cntNext      = bitCnt + 1'b1;
        end
      end
      S_TOKEN: stateNext = S_WAIT;
      S_WAIT: begin
        if (tokenRet) begin
          ctrl.loadTrailer = 1'b1;
          stateNext        = S_TRL;
          cntNext          = '0;
        end
      end
      S_TRL: begin
        ctrl.shiftEn = 1'b1;
        if (bitCnt == LAST_BIT) begin
          cntNext   = '0;
          stateNext = S_IDLE;
        end else begin
          cntNext = bitCnt + 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
    end
  end

  assign tokenOut   = (state == S_TOKEN);
  assign frameValid = (state == S_HDR) || (state == S_TRL);
  assign busy       = (state != S_IDLE);

endmodule

// File: rtl/token_readout_mgr.sv
module token_readout_mgr
  import trm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EVT_W = 8,
  parameter int LIMIT = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int WORD_W = EVT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             clrIn,
  input  logic             tokenRet,
  output logic             trigOut,
  output logic             clrOut,
  output logic             tokenOut,
  output logic             serBit,
  output logic             frameValid,
  output logic             busy,
  output logic [LVL_W-1:0] stackLevel,
  output logic             inhibit,
  output logic             ovfFlag
);
  seq_ctrl_t seqCtrl;
  logic      stackEmpty, suppLatched;

  trm_control #(.WORD_W(WORD_W)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .clrIn       (clrIn),
    .tokenRet    (tokenRet),
    .stackEmpty  (stackEmpty),
    .suppLatched (suppLatched),
    .ctrl        (seqCtrl),
    .tokenOut    (tokenOut),
    .frameValid  (frameValid),
    .busy        (busy)
  );

  trm_datapath #(
    .DEPTH(DEPTH), .EVT_W(EVT_W), .LIMIT(LIMIT), .LVL_W(LVL_W), .WORD_W(WORD_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .clrIn       (clrIn),
    .ctrl        (seqCtrl),
    .frameValid  (frameValid),
    .trigOut     (trigOut),
    .clrOut      (clrOut),
    .serBit      (serBit),
    .stackLevel  (stackLevel),
    .inhibit     (inhibit),
    .ovfFlag     (ovfFlag),
    .stackEmpty  (stackEmpty),
    .suppLatched (suppLatched)
  );

endmodule

// File: rtl/trm_checker.sv
module trm_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             trigIn,
  input logic             clrIn,
  input logic             trigOut,
  input logic             tokenOut,
  input logic             busy,
  input logic             ovfFlag,
  input logic [LVL_W-1:0] stackLevel
);
  a_r1_trig_forward: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |=> trigOut);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    stackLevel <= LVL_W'(DEPTH));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !clrIn |=> ovfFlag);

  a_r4_push_pop_level: assert property (@(posedge clk) disable iff (!rstN)
    trigIn && !clrIn && !busy && (stackLevel != '0) |=> stackLevel == $past(stackLevel));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clrIn |=> (stackLevel == '0) && !ovfFlag);

  a_r9_token_single: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);

endmodule

bind token_readout_mgr trm_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trmChecker (
  .clk        (clk),
  .rstN       (rstN),
  .trigIn     (trigIn),
  .clrIn      (clrIn),
  .trigOut    (trigOut),
  .tokenOut   (tokenOut),
  .busy       (busy),
  .ovfFlag    (ovfFlag),
  .stackLevel (stackLevel)
);

// File: tb/test_token_readout_mgr.sv
module test_token_readout_mgr;
  localparam int DEPTH  = 16;
  localparam int EVT_W  = 8;
  localparam int LIMIT  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int WORD_W = EVT_W + 2;
  localparam int ENT_W  = EVT_W + 1;

  localparam int M_IDLE = 0, M_HDR = 1, M_TOKEN = 2, M_WAIT = 3, M_TRL = 4;

  logic clk = 1'b0;
  logic rstN, trigIn, clrIn, tokenRet;
  logic trigOut, clrOut, tokenOut, serBit, frameValid, busy, inhibit, ovfFlag;
  logic [LVL_W-1:0] stackLevel;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  logic [ENT_W-1:0]  mq[$];
  logic [EVT_W-1:0]  mCnt;
  logic [WORD_W-1:0] mWord;
  int                mState, mBit;
  bit                mSupp, mOvf, mTrigOut, mClrOut;

  always #5 clk = ~clk;

  token_readout_mgr #(.DEPTH(DEPTH), .EVT_W(EVT_W), .LIMIT(LIMIT)) i_token_readout_mgr (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .clrIn(clrIn), .tokenRet(tokenRet),
    .trigOut(trigOut), .clrOut(clrOut), .tokenOut(tokenOut), .serBit(serBit),
    .frameValid(frameValid), .busy(busy), .stackLevel(stackLevel),
    .inhibit(inhibit), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] trailerWord(input bit supp, input bit ovf);
    return {2'b01, supp, ovf, {(EVT_W-2){1'b0}}};
  endfunction

  function automatic bit expSer();
    return mWord[WORD_W-1-mBit];
  endfunction

  task automatic compareAll();
    bit fv;
    fv = (mState == M_HDR) || (mState == M_TRL);
    chk("R1 trigOut", int'(trigOut), int'(mTrigOut));
    chk("R1 clrOut", int'(clrOut), int'(mClrOut));
    chk("R2 R4 R6 stackLevel", int'(stackLevel), mq.size());
    chk("R3 R6 ovfFlag", int'(ovfFlag), int'(mOvf));
    chk("R7 inhibit", int'(inhibit), int'(mq.size() > LIMIT));
    chk("R8 frameValid", int'(frameValid), int'(fv));
    chk(mSupp ? "R9 R10 tokenOut" : "R9 tokenOut", int'(tokenOut), int'(mState == M_TOKEN));
    chk("R11 busy", int'(busy), int'(mState != M_IDLE));
    if (mState == M_HDR)
      chk("R5 R8 header bit", int'(serBit), int'(expSer()));
    else if (mState == M_TRL)
      chk(mSupp ? "R10 R11 trailer bit" : "R11 trailer bit", int'(serBit), int'(expSer()));
    else
      chk("R12 serBit idle", int'(serBit), 0);
  endtask

  task automatic modelStep(input bit trig, input bit clr, input bit tok);
    int sz;
    bit pop;
    logic [ENT_W-1:0] head;
    sz   = mq.size();
    pop  = (mState == M_IDLE) && (sz > 0) && !clr;
    head = (sz > 0) ? mq[0] : '0;
    mTrigOut = trig;
    mClrOut  = clr;
    case (mState)
      M_IDLE: if (pop) begin
        mState = M_HDR; mBit = 0; mSupp = head[EVT_W];
        mWord  = {2'b10, head[EVT_W-1:0]};
      end
      M_HDR: if (mBit == WORD_W-1) begin
        mBit = 0;
        if (mSupp) begin mState = M_TRL; mWord = trailerWord(mSupp, mOvf); end
        else mState = M_TOKEN;
      end else mBit++;
      M_TOKEN: mState = M_WAIT;
      M_WAIT: if (tok) begin
        mState = M_TRL; mBit = 0; mWord = trailerWord(mSupp, mOvf);
      end
      M_TRL: if (mBit == WORD_W-1) begin mState = M_IDLE; mBit = 0; end
             else mBit++;
      default: mState = M_IDLE;
    endcase
    if (clr) begin
      mq.delete(); mCnt = '0; mOvf = 1'b0;
    end else begin
      if (pop) void'(mq.pop_front());
      if (trig) begin
        if (sz < DEPTH || pop) mq.push_back({bit'(sz > LIMIT), mCnt});
        else mOvf = 1'b1;
        mCnt = mCnt + 1'b1;
      end
    end
  endtask

  task automatic runCycle(input bit trig, input bit clr, input bit tok);
    @(negedge clk);
    compareAll();
    trigIn = trig; clrIn = clr; tokenRet = tok;
    modelStep(trig, clr, tok);
  endtask

  function automatic bit pick(input int permille);
    return ($urandom % 1000) < permille;
  endfunction

  function automatic bit tokPick();
    return (mState == M_WAIT) ? pick(300) : pick(80);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; trigIn = 1'b0; clrIn = 1'b0; tokenRet = 1'b0;
    mq.delete(); mCnt = '0; mWord = '0; mState = M_IDLE; mBit = 0;
    mSupp = 1'b0; mOvf = 1'b0; mTrigOut = 1'b0; mClrOut = 1'b0;
    repeat (3) @(negedge clk);
    compareAll();                       // reset state, R2 R3 R12
    rstN = 1'b1;
    modelStep(1'b0, 1'b0, 1'b0);

    // directed: back-to-back burst past the limit and into overflow (R3 R4 R7 R10)
    for (int i = 0; i < 24; i++) runCycle(1'b1, 1'b0, 1'b0);
    // hold queue full while the pop happens, then drain with stray returns (R9)
    for (int i = 0; i < 600; i++) runCycle(pick(40), 1'b0, tokPick());
    // directed: clear together with trigger (R6)
    runCycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) runCycle(1'b0, 1'b0, 1'b0);
    runCycle(1'b1, 1'b0, 1'b0);           // first event after clear is number 0 (R5)
    for (int i = 0; i < 80; i++) runCycle(1'b0, 1'b0, tokPick());

    // random phases with differing trigger densities
    for (int ph = 0; ph < 8; ph++) begin
      int rate;
      rate = (ph % 3 == 0) ? 500 : ((ph % 3 == 1) ? 60 : 180);
      for (int i = 0; i < 700; i++)
        runCycle(pick(rate), pick(4), tokPick());
    end

    // counter wrap: more than 256 triggers without a clear (R5)
    runCycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2500; i++) runCycle(pick(150), 1'b0, tokPick());
    for (int i = 0; i < 600; i++) runCycle(1'b0, 1'b0, tokPick());
    // clear while a readout is in progress (R6 R11)
    for (int i = 0; i < 5; i++) runCycle(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) runCycle(1'b0, 1'b0, 1'b0);
    runCycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 200; i++) runCycle(1'b0, 1'b0, tokPick());

    @(negedge clk);
    compareAll();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule